// File: doc/BRIEF.md
# Receive Byte-Boundary Strobe Generator

This block sits on the receive side of an Ethernet port and works in the receive clock domain. It searches the incoming stream for the start-of-frame delimiter. Once the delimiter is found, it produces a square-wave framing strobe whose rising edges mark the first unit of every received byte, starting with the first bit or nibble of the destination address. An external address matcher can use that strobe to latch the destination address in step with the stream.

A static mode input selects one of two stream formats. The first is a one-bit serial stream qualified by an enable. The second is a four-bit nibble stream qualified by a data-valid and a receive-error line. The aligned data is forwarded beside the strobe. After the sixth destination byte, the block registers a frame accept or reject decision. A frame is rejected if either an external reject input or an internal address-match reject input indicates rejection. The decision is held until the frame ends.

Top module: `rx_byte_strobe`

## Requirements
- R1: While reset is high, and on the first clock after reset, the strobe, the frame flag, both data outputs, the decision-valid flag and the reject output are all 0.
- R2: In serial mode (mode input 0), the stream is sampled only on clocks where the serial enable is high. The delimiter is recognised when two consecutive enabled samples are both 1, with no disabled clock between them. The next enabled sample is the first destination bit, and the clock edge that samples it raises the strobe.
- R3: In serial mode, the strobe is high for the first 4 bits of every 8-bit byte and low for the last 4. It therefore rises once per received byte.
- R4: In nibble mode (mode input 1), the delimiter is an error-free valid nibble 0x5 followed directly by an error-free valid nibble 0xD. The strobe stays low on the edge that samples 0xD and rises on the next edge, together with the first destination nibble.
- R5: In nibble mode, the strobe inverts on every clock while the frame continues. It is high for the low nibble of each byte, which is received first, and low for the high nibble.
- R6: A receive error on either delimiter nibble prevents recognition. The block keeps searching and no strobe is produced.
- R7: Outside a frame, the strobe, the frame flag, the data outputs and the decision flags are 0. When the active enable (serial enable or data-valid) drops during a frame, all of them are 0 after the next clock. A new frame then needs a complete delimiter.
- R8: During a frame, the bit output (serial mode) or nibble output (nibble mode) equals the input sampled on the same edge that updates the strobe. The unused data output is 0.
- R9: On the edge that samples the last unit of the sixth destination byte, decision-valid goes to 1 and reject is set to the OR of the external reject and internal reject inputs sampled on that edge. Both are held until the frame ends. A frame that ends earlier never raises decision-valid.
- R10: The two reject inputs have no effect on any clock other than the decision edge of R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_nib | input | 1 | 0 = serial stream, 1 = nibble stream; changed only between frames |
| ser_en | input | 1 | Serial stream enable |
| ser_dat | input | 1 | Serial data bit |
| nib_dv | input | 1 | Nibble stream data-valid |
| nib_er | input | 1 | Nibble stream receive error |
| nib_dat | input | NIB_W | Nibble data |
| ext_reject | input | 1 | External reject request |
| int_reject | input | 1 | Internal address-match reject result |
| strobe_o | output | 1 | Byte-framing strobe; a rising edge marks the first unit of a byte |
| in_frame_o | output | 1 | Forwarded data is valid |
| bit_o | output | 1 | Aligned serial data |
| nib_o | output | NIB_W | Aligned nibble data |
| decided_o | output | 1 | Accept/reject decision is valid |
| reject_o | output | 1 | 1 = frame rejected |

## Verification
Two events can fall on adjacent clock edges: capture of the accept/reject decision and the end of the frame. The capture edge is the last unit of the sixth destination byte. The bench provokes this with frames exactly six bytes long, in both modes, whose enable drops immediately after the decision unit. A reference model compares the outputs on every clock. It expects decision-valid to be 1 for exactly one cycle and then 0 together with the frame flag. Noisy reject inputs around that edge check that only the decision edge is captured.

// File: rtl/rxbs_pkg.sv
package rxbs_pkg;
  typedef enum logic {
    MODE_SER = 1'b0,
    MODE_NIB = 1'b1
  } rx_mode_e;

  localparam logic [3:0] NIB_PREAMBLE = 4'h5;
  localparam logic [3:0] NIB_SFD      = 4'hD;
endpackage

// File: rtl/rxbs_sfd_detect.sv
module rxbs_sfd_detect
  import rxbs_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  rx_mode_e         mode,
  input  logic             hunting,
  input  logic             ser_en,
  input  logic             ser_dat,
  input  logic             nib_dv,
  input  logic             nib_er,
  input  logic [NIB_W-1:0] nib_dat,
  output logic             sfd_hit
);
  logic prev_one, prev_pre;
  logic ser_one, nib_ok, nib_pre, nib_sfd;

  always_comb begin
    ser_one = (mode == MODE_SER) && ser_en && ser_dat;
    nib_ok  = (mode == MODE_NIB) && nib_dv && !nib_er;
    nib_pre = nib_ok && (nib_dat == NIB_W'(NIB_PREAMBLE));
    nib_sfd = nib_ok && (nib_dat == NIB_W'(NIB_SFD));
    sfd_hit = hunting && ((ser_one && prev_one) || (nib_sfd && prev_pre));
  end

  // History is only kept while searching; any gap or error clears it.
  always_ff @(posedge clk) begin
    if (rst || !hunting) begin
      prev_one <= 1'b0;
      prev_pre <= 1'b0;
    end else begin
      prev_one <= ser_one;
      prev_pre <= nib_pre;
    end
  end
endmodule

// File: rtl/rxbs_framer.sv
module rxbs_framer
  import rxbs_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int NIB_W      = 4,
  parameter int ADDR_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  rx_mode_e         mode,
  input  logic             sfd_hit,
  input  logic             ser_en,
  input  logic             ser_dat,
  input  logic             nib_dv,
  input  logic [NIB_W-1:0] nib_dat,
  output logic             hunting,
  output logic             frame_end,
  output logic             addr_done,
  output logic             strobe_o,
  output logic             in_frame_o,
  output logic             bit_o,
  output logic [NIB_W-1:0] nib_o
);
  localparam int NIB_UNITS = BYTE_W / NIB_W;
  localparam int CW        = $clog2(BYTE_W);
  localparam int BW        = $clog2(ADDR_BYTES + 1);

  logic          in_frame;
  logic [CW-1:0] unit_q;
  logic [BW-1:0] byte_q;
  logic          valid, last_unit;
  logic [CW-1:0] last_idx, half_idx;

  always_comb begin
    valid     = (mode == MODE_NIB) ? nib_dv : ser_en;
    last_idx  = (mode == MODE_NIB) ? CW'(NIB_UNITS - 1) : CW'(BYTE_W - 1);
    half_idx  = (mode == MODE_NIB) ? CW'(NIB_UNITS / 2) : CW'(BYTE_W / 2);
    last_unit = (unit_q == last_idx);
    hunting   = !in_frame;
    frame_end = in_frame && !valid;
    addr_done = in_frame && valid && last_unit && (byte_q == BW'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame   <= 1'b0;
      unit_q     <= '0;
      byte_q     <= '0;
      strobe_o   <= 1'b0;
      in_frame_o <= 1'b0;
      bit_o      <= 1'b0;
      nib_o      <= '0;
    end else if (!in_frame) begin
      strobe_o   <= 1'b0;
      in_frame_o <= 1'b0;
      bit_o      <= 1'b0;
      nib_o      <= '0;
      if (sfd_hit) begin
        in_frame <= 1'b1;
        unit_q   <= '0;
        byte_q   <= '0;
      end
    end else if (!valid) begin
      in_frame   <= 1'b0;
      strobe_o   <= 1'b0;
      in_frame_o <= 1'b0;
      bit_o      <= 1'b0;
      nib_o      <= '0;
    end else begin
      strobe_o   <= (unit_q < half_idx);
      in_frame_o <= 1'b1;
      bit_o      <= (mode == MODE_SER) && ser_dat;
      nib_o      <= (mode == MODE_NIB) ? nib_dat : '0;
      unit_q     <= last_unit ? '0 : unit_q + 1'b1;
      if (last_unit && byte_q != BW'(ADDR_BYTES))
        byte_q <= byte_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxbs_accept.sv
module rxbs_accept (
  input  logic clk,
  input  logic rst,
  input  logic frame_end,
  input  logic addr_done,
  input  logic ext_reject,
  input  logic int_reject,
  output logic decided_o,
  output logic reject_o
);
  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      decided_o <= 1'b0;
      reject_o  <= 1'b0;
    end else if (addr_done) begin
      decided_o <= 1'b1;
      reject_o  <= ext_reject || int_reject;
    end
  end
endmodule

// File: rtl/rx_byte_strobe.sv
module rx_byte_strobe
  import rxbs_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int NIB_W      = 4,
  parameter int ADDR_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_nib,
  input  logic             ser_en,
  input  logic             ser_dat,
  input  logic             nib_dv,
  input  logic             nib_er,
  input  logic [NIB_W-1:0] nib_dat,
  input  logic             ext_reject,
  input  logic             int_reject,
  output logic             strobe_o,
  output logic             in_frame_o,
  output logic             bit_o,
  output logic [NIB_W-1:0] nib_o,
  output logic             decided_o,
  output logic             reject_o
);
  rx_mode_e mode;
  logic     hunting, sfd_hit, frame_end, addr_done;

  assign mode = rx_mode_e'(mode_nib);

  rxbs_sfd_detect #(.NIB_W(NIB_W)) u_detect (
    .clk(clk), .rst(rst), .mode(mode), .hunting(hunting),
    .ser_en(ser_en), .ser_dat(ser_dat),
    .nib_dv(nib_dv), .nib_er(nib_er), .nib_dat(nib_dat),
    .sfd_hit(sfd_hit)
  );

  rxbs_framer #(.BYTE_W(BYTE_W), .NIB_W(NIB_W), .ADDR_BYTES(ADDR_BYTES)) u_framer (
    .clk(clk), .rst(rst), .mode(mode), .sfd_hit(sfd_hit),
    .ser_en(ser_en), .ser_dat(ser_dat), .nib_dv(nib_dv), .nib_dat(nib_dat),
    .hunting(hunting), .frame_end(frame_end), .addr_done(addr_done),
    .strobe_o(strobe_o), .in_frame_o(in_frame_o), .bit_o(bit_o), .nib_o(nib_o)
  );

  rxbs_accept u_accept (
    .clk(clk), .rst(rst), .frame_end(frame_end), .addr_done(addr_done),
    .ext_reject(ext_reject), .int_reject(int_reject),
    .decided_o(decided_o), .reject_o(reject_o)
  );
endmodule

// File: rtl/rx_byte_strobe_chk.sv
module rx_byte_strobe_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_nib,
  input logic             ser_en,
  input logic             ser_dat,
  input logic             nib_dv,
  input logic [NIB_W-1:0] nib_dat,
  input logic             strobe_o,
  input logic             in_frame_o,
  input logic             bit_o,
  input logic [NIB_W-1:0] nib_o,
  input logic             decided_o,
  input logic             reject_o
);
  logic valid;
  assign valid = mode_nib ? nib_dv : ser_en;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!strobe_o && !in_frame_o && !bit_o && nib_o == '0 && !decided_o && !reject_o));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_frame_o |-> (!strobe_o && !bit_o && nib_o == '0 && !decided_o && !reject_o));

  a_r7_drop_low: assert property (@(posedge clk) disable iff (rst)
    (in_frame_o && !valid) |=> (!in_frame_o && !strobe_o));

  a_r5_nib_toggle: assert property (@(posedge clk) disable iff (rst)
    (mode_nib && in_frame_o && nib_dv) |=> (in_frame_o && strobe_o == !$past(strobe_o)));

  a_r8_bit_align: assert property (@(posedge clk) disable iff (rst)
    (!mode_nib && in_frame_o && ser_en) |=> (bit_o == $past(ser_dat) && nib_o == '0));

  a_r8_nib_align: assert property (@(posedge clk) disable iff (rst)
    (mode_nib && in_frame_o && nib_dv) |=> (nib_o == $past(nib_dat) && !bit_o));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (decided_o && valid) |=> (decided_o && $stable(reject_o)));

  a_mode_static: assert property (@(posedge clk) disable iff (rst)
    in_frame_o |-> $stable(mode_nib));
endmodule

bind rx_byte_strobe rx_byte_strobe_chk #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .mode_nib(mode_nib), .ser_en(ser_en), .ser_dat(ser_dat),
  .nib_dv(nib_dv), .nib_dat(nib_dat), .strobe_o(strobe_o), .in_frame_o(in_frame_o),
  .bit_o(bit_o), .nib_o(nib_o), .decided_o(decided_o), .reject_o(reject_o)
);

// File: tb/rx_byte_strobe_test.sv
module rx_byte_strobe_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_nib = 1'b0;
  logic       ser_en = 1'b0, ser_dat = 1'b0;
  logic       nib_dv = 1'b0, nib_er = 1'b0;
  logic [3:0] nib_dat = 4'h0;
  logic       ext_reject = 1'b0, int_reject = 1'b0;
  logic       strobe_o, in_frame_o, bit_o, decided_o, reject_o;
  logic [3:0] nib_o;

  int checks = 0, errors = 0, rises = 0, frm_seen = 0;
  bit done = 1'b0, prev_strb = 1'b0;

  // reference model state
  bit m_in, m_prev1, m_prev5;
  int m_pos;
  bit e_strb, e_frm, e_bit, e_dec, e_rej;
  logic [3:0] e_nib;

  always #(PERIOD/2) clk = ~clk;

  rx_byte_strobe uut (
    .clk(clk), .rst(rst), .mode_nib(mode_nib), .ser_en(ser_en), .ser_dat(ser_dat),
    .nib_dv(nib_dv), .nib_er(nib_er), .nib_dat(nib_dat),
    .ext_reject(ext_reject), .int_reject(int_reject),
    .strobe_o(strobe_o), .in_frame_o(in_frame_o), .bit_o(bit_o), .nib_o(nib_o),
    .decided_o(decided_o), .reject_o(reject_o)
  );

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic model();
    bit valid, hit;
    int upb;
    valid = mode_nib ? nib_dv : ser_en;
    upb   = mode_nib ? 2 : 8;
    if (rst) begin
      m_in = 0; m_prev1 = 0; m_prev5 = 0; m_pos = 0;
      e_strb = 0; e_frm = 0; e_bit = 0; e_nib = 0; e_dec = 0; e_rej = 0;
    end else if (!m_in) begin
      e_strb = 0; e_frm = 0; e_bit = 0; e_nib = 0;
      hit = mode_nib ? (nib_dv && !nib_er && nib_dat == 4'hD && m_prev5)
                     : (ser_en && ser_dat && m_prev1);
      m_prev1 = !mode_nib && ser_en && ser_dat;
      m_prev5 = mode_nib && nib_dv && !nib_er && nib_dat == 4'h5;
      if (hit) begin m_in = 1; m_pos = 0; end
    end else begin
      m_prev1 = 0; m_prev5 = 0;
      if (!valid) begin
        m_in = 0;
        e_strb = 0; e_frm = 0; e_bit = 0; e_nib = 0; e_dec = 0; e_rej = 0;
      end else begin
        e_frm  = 1;
        e_strb = (m_pos % upb) < (upb / 2);
        e_bit  = !mode_nib && ser_dat;
        e_nib  = mode_nib ? nib_dat : 4'h0;
        if (m_pos == 6 * upb - 1) begin e_dec = 1; e_rej = ext_reject || int_reject; end
        m_pos++;
      end
    end
  endtask

  task automatic compare();
    string ts;
    ts = rst ? "R1" : (mode_nib ? "R5" : "R3");
    check(ts, "strobe", strobe_o, e_strb);
    check(rst ? "R1" : "R7", "frame flag", in_frame_o, e_frm);
    check(rst ? "R1" : "R8", "bit out", bit_o, e_bit);
    check(rst ? "R1" : "R8", "nibble out", nib_o, e_nib);
    check(rst ? "R1" : "R9", "decided", decided_o, e_dec);
    check(rst ? "R1" : "R9", "reject", reject_o, e_rej);
    if (strobe_o && !prev_strb) rises++;
    if (in_frame_o) frm_seen++;
    prev_strb = strobe_o;
  endtask

  task automatic cyc();
    @(posedge clk);
    model();
    #(PERIOD/4);
    compare();
    @(negedge clk);
  endtask

  task automatic ser_bit(bit e, bit d);
    ser_en = e; ser_dat = d; cyc();
  endtask

  task automatic nib_put(bit v, bit e, logic [3:0] n);
    nib_dv = v; nib_er = e; nib_dat = n; cyc();
  endtask

  task automatic set_rej(int u, int dec_u, bit xe, bit xi, bit noise);
    if (u != dec_u && noise) begin ext_reject = !xe; int_reject = !xi; end
    else begin ext_reject = xe; int_reject = xi; end
  endtask

  task automatic ser_frame(int nbytes, bit xe, bit xi, bit noise);
    rises = 0;
    for (int i = 0; i < 6; i++) ser_bit(1'b1, (i % 2) == 0);
    ser_bit(1'b1, 1'b1);
    ser_bit(1'b1, 1'b1);
    check("R2", "strobe low on delimiter edge", strobe_o, 0);
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] v;
      v = 8'(b * 37 + 8'h5A);
      for (int k = 0; k < 8; k++) begin
        set_rej(b * 8 + k, 47, xe, xi, noise);
        ser_bit(1'b1, v[k]);
        if (b == 0 && k == 0) check("R2", "strobe on first address bit", strobe_o, 1);
      end
    end
    check("R3", "serial strobe rises per byte", rises, nbytes);
    if (nbytes >= 6) check(noise ? "R10" : "R9", "serial reject", reject_o, xe || xi);
    ext_reject = 0; int_reject = 0;
    ser_bit(1'b0, 1'b0);
    check("R7", "serial strobe after drop", strobe_o, 0);
    ser_bit(1'b0, 1'b0);
  endtask

  task automatic nib_frame(int nbytes, bit xe, bit xi, bit noise);
    rises = 0;
    for (int i = 0; i < 5; i++) nib_put(1'b1, 1'b0, 4'h5);
    nib_put(1'b1, 1'b0, 4'hD);
    check("R4", "strobe low on delimiter edge", strobe_o, 0);
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] v;
      v = 8'(b * 53 + 8'h3C);
      set_rej(b * 2, 11, xe, xi, noise);
      nib_put(1'b1, 1'b0, v[3:0]);
      if (b == 0) begin
        check("R4", "strobe one clock after delimiter", strobe_o, 1);
        check("R4", "first address nibble", nib_o, v[3:0]);
      end
      set_rej(b * 2 + 1, 11, xe, xi, noise);
      nib_put(1'b1, 1'b0, v[7:4]);
    end
    check("R5", "nibble strobe rises per byte", rises, nbytes);
    if (nbytes >= 6) check(noise ? "R10" : "R9", "nibble reject", reject_o, xe || xi);
    ext_reject = 0; int_reject = 0;
    nib_put(1'b0, 1'b0, 4'h0);
    check("R7", "nibble strobe after drop", strobe_o, 0);
    nib_put(1'b0, 1'b0, 4'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) cyc();
    rst = 0;
    repeat (2) cyc();

    // Serial mode: accepted frame, then a 6-byte frame with noisy reject inputs (R10)
    ser_frame(8, 1'b0, 1'b0, 1'b0);
    ser_frame(6, 1'b0, 1'b1, 1'b1);
    // R9: short frame never decides
    ser_frame(3, 1'b1, 1'b1, 1'b0);

    // R2: a disabled clock between two ones does not form the delimiter
    rises = 0; frm_seen = 0;
    ser_bit(1, 1); ser_bit(1, 0); ser_bit(1, 1); ser_bit(0, 1); ser_bit(1, 1);
    for (int i = 0; i < 10; i++) ser_bit(1, 0);
    ser_bit(0, 0);
    check("R2", "gapped ones start no frame", frm_seen, 0);

    // switch mode only while idle
    mode_nib = 1'b1;
    repeat (2) cyc();

    nib_frame(8, 1'b0, 1'b1, 1'b1);
    nib_frame(6, 1'b1, 1'b0, 1'b0);
    nib_frame(7, 1'b0, 1'b0, 1'b0);

    // R6: error on the 0xD nibble, then error on the 0x5 nibble
    rises = 0; frm_seen = 0;
    for (int i = 0; i < 4; i++) nib_put(1, 0, 4'h5);
    nib_put(1, 1, 4'hD);
    for (int i = 0; i < 6; i++) nib_put(1, 0, 4'h0);
    nib_put(1, 1, 4'h5);
    nib_put(1, 0, 4'hD);
    for (int i = 0; i < 6; i++) nib_put(1, 0, 4'h1);
    nib_put(0, 0, 4'h0);
    check("R6", "errored delimiter gives no strobe", rises, 0);
    check("R6", "errored delimiter starts no frame", frm_seen, 0);

    // R7: rearm after a drop; 0xD alone must not restart a frame
    nib_frame(2, 1'b0, 1'b0, 1'b0);
    rises = 0; frm_seen = 0;
    nib_put(1, 0, 4'hD);
    for (int i = 0; i < 6; i++) nib_put(1, 0, 4'h2);
    nib_put(0, 0, 4'h0);
    check("R7", "no frame without full delimiter after rearm", frm_seen, 0);

    // back to serial for a final frame
    mode_nib = 1'b0;
    repeat (2) cyc();
    ser_frame(7, 1'b1, 1'b0, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule